// File: doc/BRIEF.md
# Programmable Clock Divider with Phase Taps

This block turns one fast source clock into three clock-level outputs. Group A runs at the source rate divided by 4, 5 or 6, as picked by a two-bit ratio select. Group B toggles at every Group A period start, so it runs at half the Group A rate with an even duty cycle. Group C is a copy of Group B held back by 0 to 3 whole source-clock periods, as picked by a two-bit skew select. A bypass input swaps the source from the oscillator clock to a reference clock, and the same ratio selection then applies to that clock. Every output is a registered level in the source-clock domain.

At the heart of the block is a three-state machine for Group A. In `ST_IDLE` all outputs stay low. The **start** transition (`ST_IDLE` to `ST_HIGH`) fires on the first source edge that sees a valid ratio code. The **hold-high** transition (`ST_HIGH` to `ST_HIGH`) runs until the high time is used up, and then **fall** (`ST_HIGH` to `ST_LOW`) is taken. **Hold-low** (`ST_LOW` to `ST_LOW`) runs to the last cycle of the period. There **wrap** (`ST_LOW` to `ST_HIGH`) loads a fresh ratio if the code is valid, and **park** (`ST_LOW` to `ST_IDLE`) is taken if the code is the unused one. Because the ratio is only sampled at a period boundary, a mid-period change of code never produces a runt pulse.

The skew taps come from a short shift register of the Group B level, and the skew select chooses which tap drives Group C. A synchronous active-high reset returns everything to the idle, all-low state.

Top module: `phase_tap_clkdiv`

## Requirements
- R1: While `rst` is high, all three outputs are low. On the first source edge after `rst` falls, with a valid ratio code and skew 0, `grp_a`, `grp_b` and `grp_c` all rise together.
- R2: With `freq_sel` = 2'b01 (bit 0 set, bit 1 clear), `grp_a` has a period of 4 source cycles and is high for 2 of them.
- R3: With `freq_sel` = 2'b00, `grp_a` has a period of 5 source cycles and is high for 2 of them, then low for 3.
- R4: With `freq_sel` = 2'b10, `grp_a` has a period of 6 source cycles and is high for 3 of them.
- R5: `grp_b` toggles on every source edge where a `grp_a` period begins, starting with a rise. It therefore has a period of 2N source cycles and is high for N of them, where N is the ratio (including N = 5). A rise of `grp_b` only ever comes together with a rise of `grp_a`.
- R6: `grp_c` equals `grp_b` delayed by K source cycles, where K is the unsigned value of `shift_sel` (0 to 3). The taps are cleared by reset.
- R7: A change of `freq_sel` is acted on only at the last source cycle of the current `grp_a` period. The current period always finishes at its old length.
- R8: `freq_sel` = 2'b11 is unused. Seen in idle, it keeps the block idle. Seen at a period boundary, it parks the block, and from the next source edge all outputs are low. A later valid code restarts the block exactly as after reset.
- R9: With `test_sel` high, the source is `ref_clk` and all periods are counted in `ref_clk` cycles. With `test_sel` low, the source is `osc_clk`. `test_sel` changes only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, the source when `test_sel` is low |
| ref_clk | input | 1 | Bypass reference clock, the source when `test_sel` is high |
| test_sel | input | 1 | Source select (1 = bypass reference) |
| rst | input | 1 | Synchronous active-high reset in the source domain |
| freq_sel | input | 2 | Ratio code: 01 gives /4, 00 gives /5, 10 gives /6, 11 is unused |
| shift_sel | input | 2 | Group C skew in whole source cycles (0 to 3) |
| grp_a | output | 1 | Group A clock level |
| grp_b | output | 1 | Group B clock level, half the Group A rate |
| grp_c | output | 1 | Group C clock level, Group B delayed by `shift_sel` |

## Verification
Every output is registered, so a change of ratio code shows first in the level sampled after the source edge that ends the current Group A period. A Group B toggle shows after the same edge as the Group A rise. A skew change reaches `grp_c` at once, through the tap mux, while the taps themselves are one register per step. The bench model advances on each source rising edge and is compared at the following falling edge; inputs are changed just after a falling edge, so model and design see them at the same rising edge. Periods, high times and skews are also measured directly by counting falling-edge samples between output edges, and in bypass mode by elapsed time between Group A rises.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } grp_a_state_e;

    localparam logic [1:0] SEL_DIV4 = 2'b01;
    localparam logic [1:0] SEL_DIV5 = 2'b00;
    localparam logic [1:0] SEL_DIV6 = 2'b10;
    localparam logic [1:0] SEL_NONE = 2'b11;

    // Period length in source cycles; zero marks the unused code.
    function automatic logic [CNT_W-1:0] ratio_of(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            SEL_DIV4: r = CNT_W'(4);
            SEL_DIV5: r = CNT_W'(5);
            SEL_DIV6: r = CNT_W'(6);
            SEL_NONE: r = '0;
        endcase
        return r;
    endfunction

    // High time in source cycles; the odd ratio is high for the shorter part.
    function automatic logic [CNT_W-1:0] high_of(input logic [1:0] code);
        logic [CNT_W-1:0] h;
        unique case (code)
            SEL_DIV4: h = CNT_W'(2);
            SEL_DIV5: h = CNT_W'(2);
            SEL_DIV6: h = CNT_W'(3);
            SEL_NONE: h = '0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux (
    input  logic osc_i,
    input  logic ref_i,
    input  logic bypass_i,
    output logic src_o
);

    // The selector is only moved while reset holds the dividers.
    assign src_o = bypass_i ? ref_i : osc_i;

endmodule

// File: rtl/grpa_div_fsm.sv
module grpa_div_fsm
    import clkdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] sel_i,
    output logic       a_o,
    output logic       start_o,
    output logic       park_o
);

    grp_a_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ratio_q, ratio_d;
    logic [CNT_W-1:0] high_q, high_d;
    logic             code_ok;
    logic             boundary;

    assign code_ok  = (ratio_of(sel_i) != '0);
    assign boundary = (state_q == ST_LOW) && (cnt_q == ratio_q - CNT_W'(1));

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ratio_q <= '0;
            high_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            high_q  <= high_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        high_d  = high_q;
        unique case (state_q)
            ST_IDLE: begin
                if (code_ok) begin           // start
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    ratio_d = ratio_of(sel_i);
                    high_d  = high_of(sel_i);
                end
            end
            ST_HIGH: begin
                cnt_d = cnt_q + CNT_W'(1);
                if ((cnt_q + CNT_W'(1)) >= high_q) begin
                    state_d = ST_LOW;        // fall
                end                          // else hold-high
            end
            ST_LOW: begin
                if (boundary) begin
                    cnt_d = '0;
                    if (code_ok) begin       // wrap
                        state_d = ST_HIGH;
                        ratio_d = ratio_of(sel_i);
                        high_d  = high_of(sel_i);
                    end else begin           // park
                        state_d = ST_IDLE;
                        ratio_d = '0;
                        high_d  = '0;
                    end
                end else begin               // hold-low
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
                ratio_d = '0;
                high_d  = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        a_o     = (state_q == ST_HIGH);
        start_o = code_ok && ((state_q == ST_IDLE) || boundary);
        park_o  = boundary && !code_ok;
    end

    // R7: the latched ratio only moves at start or wrap
    a_r7_ratio_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_IDLE && !boundary) |=> $stable(ratio_q));

    // R2: phase counter stays inside the period
    a_r2_cnt_in_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_IDLE) |-> (cnt_q < ratio_q));

    // R3: high phase never runs past the high time
    a_r3_high_in_window: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HIGH) |-> (cnt_q < high_q));

endmodule

// File: rtl/half_rate_toggle.sv
module half_rate_toggle (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic park_i,
    output logic b_o
);

    logic b_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || park_i) begin
            b_q <= 1'b0;
        end else if (start_i) begin
            b_q <= ~b_q;
        end
    end

    assign b_o = b_q;

endmodule

// File: rtl/phase_tap_delay.sv
module phase_tap_delay #(
    parameter int TAPS    = 4,
    localparam int SEL_W  = $clog2(TAPS),
    localparam int STAGES = TAPS - 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             c_o
);

    logic [STAGES-1:0] pipe_q;
    logic [TAPS-1:0]   taps;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i) begin
                if (rst_i) pipe_q <= '0;
                else       pipe_q <= b_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i) begin
                if (rst_i) pipe_q <= '0;
                else       pipe_q <= {pipe_q[STAGES-2:0], b_i};
            end
        end
    endgenerate

    assign taps = {pipe_q, b_i};
    assign c_o  = taps[sel_i];

    // R6: a one-step skew reproduces the previous Group B level
    a_r6_one_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == SEL_W'(1)) |-> (c_o == $past(b_i)));

endmodule

// File: rtl/phase_tap_clkdiv.sv
module phase_tap_clkdiv #(
    parameter int TAPS = 4,
    localparam int SHIFT_W = $clog2(TAPS)
) (
    input  logic               osc_clk,
    input  logic               ref_clk,
    input  logic               test_sel,
    input  logic               rst,
    input  logic [1:0]         freq_sel,
    input  logic [SHIFT_W-1:0] shift_sel,
    output logic               grp_a,
    output logic               grp_b,
    output logic               grp_c
);

    logic src_clk;
    logic start;
    logic park;

    clk_src_mux u_src (
        .osc_i    (osc_clk),
        .ref_i    (ref_clk),
        .bypass_i (test_sel),
        .src_o    (src_clk)
    );

    grpa_div_fsm u_fsm (
        .clk_i   (src_clk),
        .rst_i   (rst),
        .sel_i   (freq_sel),
        .a_o     (grp_a),
        .start_o (start),
        .park_o  (park)
    );

    half_rate_toggle u_half (
        .clk_i   (src_clk),
        .rst_i   (rst),
        .start_i (start),
        .park_i  (park),
        .b_o     (grp_b)
    );

    phase_tap_delay #(.TAPS(TAPS)) u_taps (
        .clk_i (src_clk),
        .rst_i (rst),
        .b_i   (grp_b),
        .sel_i (shift_sel),
        .c_o   (grp_c)
    );

    // R5: Group B only rises together with a Group A rise
    a_r5_b_rise_with_a: assert property (@(posedge src_clk) disable iff (rst)
        $rose(grp_b) |-> $rose(grp_a));

    // R8: parking drops A and B on the next edge
    a_r8_park_quiet: assert property (@(posedge src_clk) disable iff (rst)
        park |=> (!grp_a && !grp_b));

endmodule

// File: tb/tb_phase_tap_clkdiv.sv
module tb_phase_tap_clkdiv;

    logic       osc_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       test_sel = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] freq_sel = 2'b00;
    logic [1:0] shift_sel = 2'b00;
    logic       grp_a, grp_b, grp_c;
    logic       src;

    always #5 osc_clk = ~osc_clk;   // 100 MHz
    always #7 ref_clk = ~ref_clk;

    assign src = test_sel ? ref_clk : osc_clk;

    phase_tap_clkdiv dut (
        .osc_clk (osc_clk), .ref_clk (ref_clk), .test_sel (test_sel),
        .rst (rst), .freq_sel (freq_sel), .shift_sel (shift_sel),
        .grp_a (grp_a), .grp_b (grp_b), .grp_c (grp_c)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    function automatic int n_of(input logic [1:0] c);
        if (c == 2'b01) return 4;
        if (c == 2'b00) return 5;
        if (c == 2'b10) return 6;
        return 0;
    endfunction

    function automatic int hi_of(input int n);
        return (n == 5) ? 2 : n / 2;
    endfunction

    int m_off = 1;
    int m_n = 0;
    int m_ph = 0;
    bit m_b = 0;
    bit hist[$] = '{0, 0, 0, 0};

    always @(posedge src) begin
        if (rst) begin
            m_off = 1; m_ph = 0; m_b = 0; hist = '{0, 0, 0, 0};
        end else begin
            if (m_off != 0) begin
                if (n_of(freq_sel) != 0) begin
                    m_off = 0; m_n = n_of(freq_sel); m_ph = 0; m_b = !m_b;
                end
            end else if (m_ph == m_n - 1) begin
                if (n_of(freq_sel) != 0) begin
                    m_n = n_of(freq_sel); m_ph = 0; m_b = !m_b;
                end else begin
                    m_off = 1; m_ph = 0; m_b = 0;
                end
            end else begin
                m_ph++;
            end
            hist.push_front(m_b);
            void'(hist.pop_back());
        end
    end

    always @(negedge src) begin
        if (cmp_en) begin
            check(cur_req, "grp_a", int'(grp_a), (m_off == 0 && m_ph < hi_of(m_n)) ? 1 : 0);
            check(cur_req, "grp_b", int'(grp_b), int'(m_b));
            check(cur_req, "grp_c", int'(grp_c), int'(hist[shift_sel]));
        end
    end

    function automatic bit pick(input int w);
        return (w == 0) ? grp_a : ((w == 1) ? grp_b : grp_c);
    endfunction

    // Wait until the chosen output has just risen (falling-edge samples)
    task automatic wait_rise(input int w);
        bit prev;
        @(negedge src);
        prev = pick(w);
        forever begin
            @(negedge src);
            if (pick(w) && !prev) break;
            prev = pick(w);
        end
    endtask

    task automatic measure(input string req, input int w, input int exp_hi, input int exp_per);
        int hi = 0;
        int per = 0;
        bit prev;
        wait_rise(w);
        forever begin
            if (pick(w)) hi++;
            per++;
            prev = pick(w);
            @(negedge src);
            if (pick(w) && !prev) break;
        end
        check(req, "high cycles", hi, exp_hi);
        check(req, "period cycles", per, exp_per);
    endtask

    task automatic measure_skew(input string req, input int exp);
        int k = 0;
        wait_rise(1);
        while (!grp_c && k < 20) begin
            @(negedge src);
            k++;
        end
        check(req, "c skew", k, exp);
    endtask

    initial begin
        repeat (4) @(negedge src);
        check("R1", "grp_a in reset", int'(grp_a), 0);
        check("R1", "grp_b in reset", int'(grp_b), 0);
        check("R1", "grp_c in reset", int'(grp_c), 0);
        cmp_en = 1;
        #1 rst = 1'b0;
        @(negedge src);
        check("R1", "grp_a first edge", int'(grp_a), 1);
        check("R1", "grp_b first edge", int'(grp_b), 1);
        check("R1", "grp_c first edge", int'(grp_c), 1);

        cur_req = "R3";
        measure("R3", 0, 2, 5);
        measure("R5", 1, 5, 10);

        // R7: change the code right at a Group A rise; old period must finish
        cur_req = "R7";
        wait_rise(0);
        #1 freq_sel = 2'b01;
        begin
            int k = 0;
            bit prev = 1;
            forever begin
                @(negedge src);
                k++;
                if (grp_a && !prev) break;
                prev = grp_a;
            end
            check("R7", "old period kept", k, 5);
        end

        cur_req = "R2";
        measure("R2", 0, 2, 4);
        measure("R5", 1, 4, 8);

        @(negedge src); #1 freq_sel = 2'b10;
        cur_req = "R4";
        measure("R4", 0, 3, 6);
        measure("R5", 1, 6, 12);

        cur_req = "R6";
        for (int s = 0; s < 4; s++) begin
            @(negedge src); #1 shift_sel = 2'(s);
            measure_skew("R6", s);
            measure("R6", 2, 6, 12);
        end

        cur_req = "R8";
        @(negedge src); #1 freq_sel = 2'b11; shift_sel = 2'b00;
        repeat (20) @(negedge src);
        check("R8", "grp_a parked", int'(grp_a), 0);
        check("R8", "grp_b parked", int'(grp_b), 0);
        check("R8", "grp_c parked", int'(grp_c), 0);
        #1 freq_sel = 2'b00;
        @(negedge src);
        check("R8", "grp_a restart", int'(grp_a), 1);
        check("R8", "grp_b restart", int'(grp_b), 1);
        measure("R8", 0, 2, 5);

        // R9: bypass reference clock
        cmp_en = 0;
        @(negedge src); #1 rst = 1'b1;
        repeat (3) @(negedge src);
        #1 test_sel = 1'b1; freq_sel = 2'b10;
        repeat (4) @(negedge src);
        cmp_en = 1;
        cur_req = "R9";
        #1 rst = 1'b0;
        measure("R9", 0, 3, 6);
        begin
            longint t0, t1;
            wait_rise(0);
            t0 = $time;
            wait_rise(0);
            t1 = $time;
            check("R9", "period time units", int'(t1 - t0), 84);
        end
        repeat (10) @(negedge src);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge osc_clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule